// File: doc/BRIEF.md
# Coefficient RAM with Power-Up Zero Sweep

This block is a single-write-port memory with a synchronous, read-first read port. It holds coefficient words of 64 bits by default. The storage array has no reset term of its own. After a synchronous reset, a small controller walks the address space from the lowest location to the highest, one location per clock. It drives zero into each one through the same write port that the host uses in normal operation.

During that sweep the controller owns the write port. Host write requests are dropped, and the read register keeps its value. A ready flag tells the host when the contents can be trusted.

A parameter adds an optional second output register. Read latency is then two cycles instead of one.

Top module: `sweep_clear_ram`

## Requirements
- R1: Once reset is released, the block writes zero to every location in ascending address order, one per clock starting at address 0. After the sweep, every location reads back as zero.
- R2: `ready` is 0 while `rst` is high and during the sweep. It becomes 1 exactly DEPTH rising edges after the first edge at which `rst` is sampled low, and it then stays 1 until the next reset.
- R3: The sweep uses the single write port of the array. Its data is the host data path gated to zero, so any write made while `ready` is 0 stores zero.
- R4: Host writes presented while the sweep runs have no effect. A value written to address 0 during the sweep still reads back as zero afterwards.
- R5: With `ready` high, `en`=1 and `we`=1 store `wdata` at `addr` on the clock edge. With `en`=0, nothing is written and the read data holds its previous value.
- R6: A read with `en`=1 registers the contents of `addr` as they were before that edge (read-first). A combined write and read of one address returns the old word.
- R7: With OUT_REG=0, the data for a request sampled at edge k appears on `rdata` after edge k. With OUT_REG=1, it appears one edge later, because the extra stage loads every cycle.
- R8: The read register clears to zero on reset. It stays unchanged for the whole sweep, even when the host asserts `en`.
- R9: A reset asserted part-way through a sweep restarts it from address 0. `ready` then needs the full DEPTH edges again, and a location written before the interrupted sweep reads zero afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; starts a new sweep |
| en | input | 1 | Access enable qualifying both read and write |
| we | input | 1 | Write request when `en` is high |
| addr | input | AW | Host word address, AW = log2(DEPTH) |
| wdata | input | DATA_W | Host write data |
| rdata | output | DATA_W | Registered read data |
| ready | output | 1 | High once the zero sweep has completed |

## Verification
A host request is driven after a falling edge and sampled by the next rising edge. The single-stage instance shows the result at the following falling edge, and the two-stage instance shows it one falling edge later. The bench compares each instance at exactly that point, so the second instance is always checked against the previous row of the vector table. `ready` is counted edge by edge from the release of reset. It is checked to be low at edge DEPTH-1 and high at edge DEPTH, both for a clean reset and for a reset that interrupts a sweep.

// File: rtl/scr_pkg.sv
package scr_pkg;
    typedef enum logic {
        PH_SWEEP = 1'b0,
        PH_READY = 1'b1
    } phase_e;
endpackage

// File: rtl/scr_sweep_ctrl.sv
module scr_sweep_ctrl #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    output logic          sweeping,
    output logic [AW-1:0] sweep_addr,
    output logic          done
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        scr_pkg::phase_e ph;
        logic [AW-1:0]   cnt;
    } ctl_t;

    ctl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.ph == scr_pkg::PH_SWEEP) begin
            if (st_q.cnt == LAST) begin
                st_d.ph = scr_pkg::PH_READY;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        if (rst) begin
            st_d.ph  = scr_pkg::PH_SWEEP;
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sweeping   = (st_q.ph == scr_pkg::PH_SWEEP);
    assign done       = (st_q.ph == scr_pkg::PH_READY);
    assign sweep_addr = st_q.cnt;

    // R1: the sweep address advances by one each clock until the last location
    a_r1_sweep_step: assert property (@(posedge clk) disable iff (rst)
        (sweeping && sweep_addr != LAST) |=> (sweep_addr == $past(sweep_addr) + 1'b1));

    // R2: once done, the controller stays done until reset
    a_r2_ready_sticky: assert property (@(posedge clk) disable iff (rst)
        done |=> done);
endmodule

// File: rtl/scr_array.sv
module scr_array #(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 64,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [AW-1:0]     port_addr,
    input  logic [DATA_W-1:0] port_din,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_d, rd_q;

    // storage carries no reset term
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[port_addr] <= port_din;
        end
    end

    always_comb begin
        rd_d = rd_q;
        if (rd_en) begin
            rd_d = mem[port_addr];
        end
        if (rst) begin
            rd_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        rd_q <= rd_d;
    end

    assign rd_data = rd_q;

    // R8: without a read request the read register holds its value
    a_r8_read_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/scr_out_stage.sv
module scr_out_stage #(
    parameter int DATA_W  = 64,
    parameter bit OUT_REG = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    generate
        if (OUT_REG) begin : g_reg
            logic [DATA_W-1:0] pipe_d, pipe_q;

            always_comb begin
                pipe_d = din;
                if (rst) begin
                    pipe_d = '0;
                end
            end

            always_ff @(posedge clk) begin
                pipe_q <= pipe_d;
            end

            assign dout = pipe_q;

            // R7: the extra stage delays read data by exactly one clock
            a_r7_one_cycle_delay: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> (dout == $past(din)));
        end else begin : g_pass
            assign dout = din;
        end
    endgenerate
endmodule

// File: rtl/sweep_clear_ram.sv
module sweep_clear_ram #(
    parameter int DATA_W  = 64,
    parameter int DEPTH   = 64,
    parameter bit OUT_REG = 1'b0,
    parameter int AW      = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ready
);
    logic              sweeping;
    logic              done;
    logic [AW-1:0]     sweep_addr;
    logic              arr_we;
    logic              arr_rd;
    logic [AW-1:0]     arr_addr;
    logic [DATA_W-1:0] arr_din;
    logic [DATA_W-1:0] arr_dout;

    scr_sweep_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .sweeping   (sweeping),
        .sweep_addr (sweep_addr),
        .done       (done)
    );

    // one write port: the sweep takes it over and gates the data to zero
    always_comb begin
        arr_addr = sweeping ? sweep_addr : addr;
        arr_din  = wdata & {DATA_W{~sweeping}};
        arr_we   = ~rst & (sweeping | (en & we));
        arr_rd   = ~rst & done & en;
    end

    scr_array #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_array (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (arr_we),
        .rd_en     (arr_rd),
        .port_addr (arr_addr),
        .port_din  (arr_din),
        .rd_data   (arr_dout)
    );

    scr_out_stage #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_out (
        .clk  (clk),
        .rst  (rst),
        .din  (arr_dout),
        .dout (rdata)
    );

    assign ready = done;

    // R3/R4: any array write issued before ready carries zero data
    a_r3_sweep_zero_data: assert property (@(posedge clk) disable iff (rst)
        (!ready && arr_we) |-> (arr_din == '0));

    // R4: before ready, the array address follows the sweep, never the host
    a_r4_host_locked_out: assert property (@(posedge clk) disable iff (rst)
        (!ready && arr_we) |-> (arr_addr == sweep_addr));
endmodule

// File: tb/test_sweep_clear_ram.sv
`timescale 1ns/1ps
module test_sweep_clear_ram;
    localparam int DW = 64;
    localparam int DEPTH = 64;
    localparam int AW = 6;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst = 1'b1;
    logic          en = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata_a, rdata_b;
    logic          ready_a, ready_b;

    int n_chk = 0;
    int n_bad = 0;

    sweep_clear_ram #(.DATA_W(DW), .DEPTH(DEPTH), .OUT_REG(1'b0)) i_sweep_clear_ram (
        .clk(clk), .rst(rst), .en(en), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata_a), .ready(ready_a));

    sweep_clear_ram #(.DATA_W(DW), .DEPTH(DEPTH), .OUT_REG(1'b1)) i_sweep_clear_ram_reg (
        .clk(clk), .rst(rst), .en(en), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata_b), .ready(ready_b));

    typedef struct packed {
        logic          w;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic [DW-1:0] exp;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 6'd5,  64'h0000_0000_0000_00A1, 64'h0},
        '{1'b0, 6'd5,  64'h0,                   64'h0000_0000_0000_00A1},
        '{1'b1, 6'd5,  64'hB2B2_0000_0000_00B2, 64'h0000_0000_0000_00A1},
        '{1'b0, 6'd5,  64'h0,                   64'hB2B2_0000_0000_00B2},
        '{1'b1, 6'd63, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
        '{1'b0, 6'd63, 64'h0,                   64'hFFFF_FFFF_FFFF_FFFF},
        '{1'b0, 6'd0,  64'h0,                   64'h0},
        '{1'b1, 6'd0,  64'h0000_0000_0000_1234, 64'h0},
        '{1'b0, 6'd0,  64'h0,                   64'h0000_0000_0000_1234}
    };

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // release reset, hammer address 0 with host writes, count edges to ready
    task automatic sweep_timed(input string tag);
        rst = 1'b0; en = 1'b1; we = 1'b1; addr = '0; wdata = 64'hDEAD_BEEF_DEAD_BEEF;
        for (int k = 1; k <= DEPTH; k++) begin
            @(negedge clk);
            if (k == DEPTH / 2) begin
                chk({tag, " R8 rdata zero mid-sweep (1-stage)"}, rdata_a, '0);
                chk({tag, " R8 rdata zero mid-sweep (2-stage)"}, rdata_b, '0);
            end
            if (k == DEPTH - 1) chk({tag, " R2 ready low at edge DEPTH-1"}, DW'(ready_a), '0);
            if (k == DEPTH) begin
                chk({tag, " R2 ready high at edge DEPTH"}, DW'(ready_a), DW'(1));
                chk({tag, " R2 ready high at edge DEPTH (2-stage)"}, DW'(ready_b), DW'(1));
            end
        end
        en = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] exp);
        en = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        en = 1'b0;
        chk({tag, " (1-stage)"}, rdata_a, exp);
        @(negedge clk);
        chk({tag, " R7 (2-stage)"}, rdata_b, exp);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R2 ready low in reset", DW'(ready_a), '0);
        chk("R8 rdata zero in reset (1-stage)", rdata_a, '0);
        chk("R8 rdata zero in reset (2-stage)", rdata_b, '0);

        sweep_timed("first");
        rd("R4 host write during sweep ignored", 6'd0, '0);
        rd("R1 mid location cleared", 6'd37, '0);
        rd("R1 last location cleared", 6'd63, '0);

        // vector table: single-stage result after one edge, two-stage one later
        for (int i = 0; i < NV; i++) begin
            en = 1'b1; we = VEC[i].w; addr = VEC[i].a; wdata = VEC[i].d;
            @(negedge clk);
            chk($sformatf("R6 R5 vec %0d (1-stage)", i), rdata_a, VEC[i].exp);
            if (i > 0) chk($sformatf("R7 vec %0d (2-stage)", i - 1), rdata_b, VEC[i-1].exp);
        end
        en = 1'b0; we = 1'b0;
        @(negedge clk);
        chk("R7 last vec (2-stage)", rdata_b, VEC[NV-1].exp);

        // enable low: write ignored, read data held
        en = 1'b0; we = 1'b1; addr = 6'd0; wdata = 64'hFFFF_0000_FFFF_0000;
        @(negedge clk);
        we = 1'b0;
        chk("R5 rdata held with en low", rdata_a, 64'h1234);
        rd("R5 write with en low ignored", 6'd0, 64'h1234);

        // R9: interrupted sweep restarts from the beginning
        en = 1'b1; we = 1'b1; addr = 6'd7; wdata = 64'h77;
        @(negedge clk);
        en = 1'b0; we = 1'b0;
        rd("R5 pre-reset write stored", 6'd7, 64'h77);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (30) @(negedge clk);
        chk("R9 ready low part-way", DW'(ready_a), '0);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        sweep_timed("R9 restart");
        rd("R9 location cleared after restart", 6'd7, '0);
        rd("R9 address 0 cleared after restart", 6'd0, '0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule